// File: doc/BRIEF.md
# Horizontal Sync Polarity Normalizer and Regenerator

This block accepts a horizontal sync signal whose active level is not known in advance. It learns which level is active by comparing how long the signal spends high and how long it spends low. It uses the leading edge of the normalized sync as the timing reference for the line. From that edge it emits a fresh sync pulse. The width of that pulse, in pixel clocks, comes from a configuration input and never from the incoming pulse. Its active level is set by a single configuration bit.

The emitted pulse can be held back by a programmable number of pixel clocks equal to the latency of the data path. The edge then lines up with the sample that was captured when the sync edge arrived. Downstream display logic sees a fixed timing relationship between sync, data clock and data.

The raw input is brought into the pixel clock domain through two flip-flops before any edge or level decision is made. The polarity decision is taken at the end of fixed-length measurement windows. It changes only when two windows in a row agree.

Top module: `hsync_regen`

## Requirements
- R1: While reset is asserted and just after it is released, the detector assumes an active-high input and no pulse is active. `sync_out` rests at its inactive level: 0 when `out_active_high` is 1, and 1 when it is 0.
- R2: With `pipe_delay` = 0, a leading edge of the normalized input makes `sync_out` active in the third pixel clock after the first clock edge that sees the raw change. That latency is two synchronizer stages plus one edge register. Only leading edges start a pulse; a trailing edge starts none.
- R3: A pulse stays active for exactly `pulse_width` consecutive pixel clocks.
- R4: A `pulse_width` of 0 produces a pulse one pixel clock long.
- R5: Each unit of `pipe_delay` postpones the start of the pulse by one pixel clock and leaves its width unchanged.
- R6: `out_active_high` = 1 makes the pulse a high level on `sync_out`; 0 makes it a low level.
- R7: At the end of each window of WIN_LEN pixel clocks, the level that was present for the fewer clocks is taken as the candidate active level. The candidate is active-high when twice the high count is less than WIN_LEN, and active-low otherwise. The decision adopts the candidate when the previous window gave the same candidate.
- R8: A single window whose candidate differs from the previous window's candidate leaves the decision unchanged.
- R9: A leading edge that arrives while a pulse is active restarts the width count, so the pulse ends `pulse_width` clocks after the later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_raw | input | 1 | Incoming horizontal sync, either polarity, asynchronous |
| out_active_high | input | 1 | Output polarity select: 1 active high, 0 active low |
| pulse_width | input | WID_W | Output pulse width in pixel clocks (0 means 1) |
| pipe_delay | input | DLY_W | Extra pixel clocks of delay to match the data path |
| sync_out | output | 1 | Regenerated horizontal sync |

## Verification
Single short raw pulses are fired from a settled idle level. The measured start clock and active length separate the synchronizer latency, the delay setting and the width setting; the length also shows whether a trailing edge wrongly fires a second pulse. Two closely spaced leading edges show whether the count restarts or the pulses merge wrongly. An input that rests high starts with the default active-high decision. It shows, within the second window, that a pulse is still launched by the rising edge; after further windows the falling edge launches it. Idling low again afterwards tells the shorter-level rule apart from a rule that simply holds the last decision.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

    typedef enum logic {
        POL_LOW  = 1'b0,
        POL_HIGH = 1'b1
    } pol_e;

endpackage

// File: rtl/hsr_polarity_detect.sv
module hsr_polarity_detect
    import hsr_pkg::*;
#(
    parameter int unsigned WIN_LEN = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic lead_edge,
    output pol_e act_pol
);

    localparam int unsigned WC_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
    localparam logic [WC_W-1:0] WC_LAST = WC_W'(WIN_LEN - 1);
    localparam logic [WC_W+1:0] WIN_CMP = (WC_W + 2)'(WIN_LEN);

    typedef struct packed {
        logic            meta;
        logic            synced;
        logic            norm_prev;
        logic [WC_W-1:0] win_cnt;
        logic [WC_W:0]   high_cnt;
        pol_e            prev_cand;
        pol_e            decided;
    } det_state_t;

    det_state_t q, d;

    logic          norm;
    logic          win_end;
    logic [WC_W:0] high_total;
    logic [WC_W+1:0] high_dbl;
    pol_e          cand;

    always_comb begin
        d = q;
        d.meta   = raw_in;
        d.synced = q.meta;

        norm = (q.decided == POL_HIGH) ? q.synced : ~q.synced;
        d.norm_prev = norm;

        high_total = q.high_cnt + {{WC_W{1'b0}}, q.synced};
        high_dbl   = {high_total, 1'b0};
        cand       = (high_dbl < WIN_CMP) ? POL_HIGH : POL_LOW;
        win_end    = (q.win_cnt == WC_LAST);

        if (win_end) begin
            d.win_cnt   = '0;
            d.high_cnt  = '0;
            d.prev_cand = cand;
            if (cand == q.prev_cand) begin
                d.decided = cand;
            end
        end else begin
            d.win_cnt  = q.win_cnt + 1'b1;
            d.high_cnt = high_total;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.meta      <= 1'b0;
            q.synced    <= 1'b0;
            q.norm_prev <= 1'b0;
            q.win_cnt   <= '0;
            q.high_cnt  <= '0;
            q.prev_cand <= POL_HIGH;
            q.decided   <= POL_HIGH;
        end else begin
            q <= d;
        end
    end

    assign lead_edge = norm & ~q.norm_prev;
    assign act_pol   = q.decided;

    // R7
    mid_window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(q.decided));

    // R7
    agree_adopt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && cand == q.prev_cand) |=> (q.decided == $past(cand)));

    // R8
    single_window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && cand != q.prev_cand) |=> $stable(q.decided));

endmodule

// File: rtl/hsr_edge_delay.sv
module hsr_edge_delay #(
    parameter int unsigned DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_in,
    input  logic [DLY_W-1:0] sel,
    output logic             edge_out
);

    localparam int unsigned DEPTH = (1 << DLY_W) - 1;

    typedef struct packed {
        logic [DEPTH-1:0] sh;
    } dly_state_t;

    dly_state_t q, d;
    logic [DEPTH:0] taps;

    assign taps[0] = edge_in;

    for (genvar k = 0; k < DEPTH; k++) begin : g_tap
        assign taps[k+1] = q.sh[k];
    end

    always_comb begin
        d.sh = {q.sh[DEPTH-2:0], edge_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.sh <= '0;
        end else begin
            q <= d;
        end
    end

    assign edge_out = taps[sel];

    // R5
    first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_in |=> q.sh[0]);

    // R5
    stage_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.sh[0] |=> q.sh[1]);

endmodule

// File: rtl/hsr_pulse_gen.sv
module hsr_pulse_gen #(
    parameter int unsigned WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WID_W-1:0] width,
    output logic             pulse_on
);

    typedef struct packed {
        logic [WID_W-1:0] remain;
    } pg_state_t;

    pg_state_t q, d;
    logic [WID_W-1:0] width_eff;

    always_comb begin
        width_eff = (width == '0) ? {{(WID_W-1){1'b0}}, 1'b1} : width;
        d = q;
        if (start) begin
            d.remain = width_eff;
        end else if (q.remain != '0) begin
            d.remain = q.remain - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.remain <= '0;
        end else begin
            q <= d;
        end
    end

    assign pulse_on = (q.remain != '0);

    // R3
    load_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (q.remain == $past(width_eff)));

    // R3
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && q.remain != '0) |=> (q.remain == $past(q.remain) - 1'b1));

    // R4
    idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && q.remain == '0) |=> !pulse_on);

endmodule

// File: rtl/hsync_regen.sv
module hsync_regen
    import hsr_pkg::*;
#(
    parameter int unsigned WIN_LEN = 1024,
    parameter int unsigned WID_W   = 8,
    parameter int unsigned DLY_W   = 4
) (
    input  logic             clk_pix,
    input  logic             rst_n,
    input  logic             sync_raw,
    input  logic             out_active_high,
    input  logic [WID_W-1:0] pulse_width,
    input  logic [DLY_W-1:0] pipe_delay,
    output logic             sync_out
);

    logic lead_w;
    logic edge_dly_w;
    logic pulse_on_w;
    pol_e act_pol_w;

    hsr_polarity_detect #(
        .WIN_LEN (WIN_LEN)
    ) i_detect (
        .clk       (clk_pix),
        .rst_n     (rst_n),
        .raw_in    (sync_raw),
        .lead_edge (lead_w),
        .act_pol   (act_pol_w)
    );

    hsr_edge_delay #(
        .DLY_W (DLY_W)
    ) i_delay (
        .clk      (clk_pix),
        .rst_n    (rst_n),
        .edge_in  (lead_w),
        .sel      (pipe_delay),
        .edge_out (edge_dly_w)
    );

    hsr_pulse_gen #(
        .WID_W (WID_W)
    ) i_pulse (
        .clk      (clk_pix),
        .rst_n    (rst_n),
        .start    (edge_dly_w),
        .width    (pulse_width),
        .pulse_on (pulse_on_w)
    );

    assign sync_out = out_active_high ? pulse_on_w : ~pulse_on_w;

    // R2
    zero_delay_start_chk: assert property (@(posedge clk_pix) disable iff (!rst_n)
        (lead_w && pipe_delay == '0) |=> pulse_on_w);

    // R1
    reset_quiet_chk: assert property (@(posedge clk_pix)
        !rst_n |=> (!pulse_on_w && act_pol_w == POL_HIGH));

endmodule

// File: tb/test_hsync_regen.sv
`timescale 1ns/1ps
module test_hsync_regen;

    localparam int WIN_LEN = 64;
    localparam int WID_W   = 8;
    localparam int DLY_W   = 4;
    localparam real CLK_P  = 8.0;

    logic             clk_pix = 1'b0;
    logic             rst_n;
    logic             sync_raw;
    logic             out_active_high;
    logic [WID_W-1:0] pulse_width;
    logic [DLY_W-1:0] pipe_delay;
    logic             sync_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #(CLK_P/2) clk_pix = ~clk_pix;

    hsync_regen #(
        .WIN_LEN (WIN_LEN),
        .WID_W   (WID_W),
        .DLY_W   (DLY_W)
    ) i_hsync_regen (
        .clk_pix         (clk_pix),
        .rst_n           (rst_n),
        .sync_raw        (sync_raw),
        .out_active_high (out_active_high),
        .pulse_width     (pulse_width),
        .pipe_delay      (pipe_delay),
        .sync_out        (sync_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_pix);
    endtask

    task automatic do_reset(input logic raw_lvl);
        @(negedge clk_pix);
        rst_n = 1'b0;
        sync_raw = raw_lvl;
        idle(4);
        rst_n = 1'b1;
    endtask

    // Fire one raw pulse away from idle_lvl at index 0, return at back_at,
    // and measure first active sample index and active length.
    task automatic shoot(input logic idle_lvl, input int back_at,
                         input int exp_first, input int exp_len, input string req);
        int first = -1;
        int len = 0;
        @(negedge clk_pix);
        sync_raw = ~idle_lvl;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk_pix);
            if (sync_out == out_active_high) begin
                if (first < 0) first = i;
                len++;
            end
            if (i == back_at) sync_raw = idle_lvl;
        end
        check(first == exp_first, {req, " start"}, first, exp_first);
        check(len == exp_len, {req, " length"}, len, exp_len);
    endtask

    task automatic t_reset();
        out_active_high = 1'b1;
        do_reset(1'b0);
        check(sync_out == 1'b0, "R1 idle high-active", int'(sync_out), 0);
        idle(10);
        check(sync_out == 1'b0, "R1 idle after release", int'(sync_out), 0);
    endtask

    task automatic t_basic();
        pulse_width = 8'd4; pipe_delay = '0;
        // R2 R3: start at 3, four clocks, no pulse from the trailing edge
        shoot(1'b0, 3, 3, 4, "R2 R3 basic");
        pulse_width = 8'd9;
        shoot(1'b0, 12, 3, 9, "R3 long raw pulse");
    endtask

    task automatic t_delay();
        pulse_width = 8'd7; pipe_delay = 4'd5;
        shoot(1'b0, 2, 8, 7, "R5 delay 5");
        pipe_delay = 4'd15;
        shoot(1'b0, 2, 18, 7, "R5 delay max");
        pipe_delay = '0;
    endtask

    task automatic t_zero_width();
        pulse_width = 8'd0;
        shoot(1'b0, 3, 3, 1, "R4 zero width");
    endtask

    task automatic t_out_pol();
        pulse_width = 8'd4;
        out_active_high = 1'b0;
        @(negedge clk_pix);
        check(sync_out == 1'b1, "R6 inactive level low-active", int'(sync_out), 1);
        shoot(1'b0, 3, 3, 4, "R6 low-active pulse");
        out_active_high = 1'b1;
        @(negedge clk_pix);
        check(sync_out == 1'b0, "R6 inactive level high-active", int'(sync_out), 0);
    endtask

    task automatic t_restart();
        int first = -1;
        int len = 0;
        pulse_width = 8'd10; pipe_delay = '0;
        @(negedge clk_pix);
        sync_raw = 1'b1;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk_pix);
            if (sync_out) begin
                if (first < 0) first = i;
                len++;
            end
            if (i == 2) sync_raw = 1'b0;
            if (i == 4) sync_raw = 1'b1;
            if (i == 6) sync_raw = 1'b0;
        end
        // R9: edges at 0 and 4 -> active from 3 through 4+3+10-1 = 16
        check(first == 3, "R9 restart start", first, 3);
        check(len == 14, "R9 restart length", len, 14);
    endtask

    task automatic t_polarity();
        pulse_width = 8'd5; pipe_delay = '0; out_active_high = 1'b1;
        do_reset(1'b1);
        idle(72);
        // R8: first window disagreed, so the rising edge still launches it
        shoot(1'b1, 3, 6, 5, "R8 one window no change");
        idle(200);
        // R7: two windows of mostly-high input -> active low
        shoot(1'b1, 3, 3, 5, "R7 detected active low");
        sync_raw = 1'b0;
        idle(200);
        // R7: mostly-low input -> back to active high
        shoot(1'b0, 3, 3, 5, "R7 detected active high");
    endtask

    initial begin
        rst_n = 1'b0;
        sync_raw = 1'b0;
        out_active_high = 1'b1;
        pulse_width = 8'd4;
        pipe_delay = '0;
        t_reset();
        t_basic();
        t_delay();
        t_zero_width();
        t_out_pol();
        t_restart();
        t_polarity();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule